// File: doc/BRIEF.md
# Per-Core Converter Power Mode Controller

This block sets the power state of each converter core to normal, nap or sleep. It drives one nap enable and one sleep enable for each core.

By default every core follows a tri-level mode pin. The pin arrives already decoded as a two-bit level code and passes through two synchronising flops. Software can override the pin one core at a time. It writes a three-bit mode code to the register selected by the core index, and each core keeps its own register. A nonzero code overrides the pin for that core only. The code 000 hands that core back to the pin. In pin mode the pin's level applies to every core that is not overridden.

A hard reset clears all mode registers to pin control. A soft reset reinitialises only the pin synchroniser and leaves the mode registers and core states alone.

Each core runs a three-state machine with states ST_NORMAL, ST_NAP and ST_SLEEP. Its transitions are named by their source:
- REG_GO: a valid nonzero register code moves the core to the coded state.
- PIN_GO: in pin control, a defined pin level moves the core to the mapped state.
- HOLD: an undefined pin level keeps the current state.

Any state can reach any other state through REG_GO or PIN_GO.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After hard reset (rst_n low) every mode register reads 000, and every core is in normal state with nap_en and sleep_en low.
- R2: A core whose register holds 000 follows the pin level code. Code 00 (low) selects sleep, 01 (mid) selects normal and 10 (high) selects nap. The outputs change on the third rising edge after the pin changes.
- R3: Pin code 11 is undefined. Cores under pin control hold their current state while it is applied.
- R4: A write of 001, 010 or 100 stores the code for the indexed core, and that core becomes normal, nap or sleep respectively one edge after the write edge. Other cores are not affected.
- R5: Writing 000 returns the indexed core to pin control. From the next edge it takes the state given by the synchronised pin level.
- R6: A write of any code other than 000, 001, 010 or 100 is dropped. The register and every core state stay unchanged.
- R7: Changing core_idx alters no core state. rd_data always returns the register of the currently indexed core.
- R8: soft_rst leaves all mode registers and register-driven core states unchanged. It sets both pin synchroniser stages to the mid (normal) code.
- R9: nap_en and sleep_en are never high together for the same core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset; pin synchroniser only |
| pin_lvl | input | 2 | Decoded tri-level pin code: 00 low, 01 mid, 10 high |
| wr_en | input | 1 | Mode register write strobe |
| core_idx | input | IDX_W | Core selected for write and readback |
| wr_data | input | 3 | Mode code to write |
| rd_data | output | 3 | Mode register of the indexed core |
| nap_en | output | NUM_CORES | Per-core nap enable |
| sleep_en | output | NUM_CORES | Per-core sleep enable |

## Verification
The pin is stepped through all four codes while both cores are under pin control, with the undefined code applied between defined levels. This separates the per-level mapping and the three-edge latency from the hold behaviour.

Each core is then given a different register code, and the pin is moved underneath. This shows that the override is per core and that the index alone never moves a state.

Illegal codes, a 000 write and a soft reset pulse follow. These tell dropped writes, the return to pin control and the synchroniser-only soft reset apart from a full clear.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_NAP    = 2'd1,
        ST_SLEEP  = 2'd2
    } pstate_t;

    localparam logic [2:0] CODE_PIN    = 3'b000;
    localparam logic [2:0] CODE_NORMAL = 3'b001;
    localparam logic [2:0] CODE_NAP    = 3'b010;
    localparam logic [2:0] CODE_SLEEP  = 3'b100;

    localparam logic [1:0] LVL_LOW  = 2'b00;
    localparam logic [1:0] LVL_MID  = 2'b01;
    localparam logic [1:0] LVL_HIGH = 2'b10;

    function automatic logic code_is_legal(input logic [2:0] code);
        return (code == CODE_PIN) || (code == CODE_NORMAL) ||
               (code == CODE_NAP) || (code == CODE_SLEEP);
    endfunction

endpackage

// File: rtl/pwr_pin_sync.sv
module pwr_pin_sync
    import pwr_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic [1:0] lvl_in,
    output logic [1:0] lvl_sync
);
    logic [1:0] stage1_q;
    logic [1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= LVL_MID;
            stage2_q <= LVL_MID;
        end else if (soft_rst) begin
            stage1_q <= LVL_MID;
            stage2_q <= LVL_MID;
        end else begin
            stage1_q <= lvl_in;
            stage2_q <= stage1_q;
        end
    end

    assign lvl_sync = stage2_q;
endmodule

// File: rtl/pwr_mode_regs.sv
module pwr_mode_regs
    import pwr_mode_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int IDX_W     = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       core_idx,
    input  logic [2:0]             wr_data,
    output logic [2:0]             rd_data,
    output logic [NUM_CORES*3-1:0] mode_flat
);
    logic [2:0] mode_q [NUM_CORES];
    logic       idx_ok;

    assign idx_ok = (int'(core_idx) < NUM_CORES);

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mode_q[g] <= CODE_PIN;
            end else if (wr_en && idx_ok && (int'(core_idx) == g) &&
                         code_is_legal(wr_data)) begin
                mode_q[g] <= wr_data;
            end
        end
        assign mode_flat[g*3 +: 3] = mode_q[g];
    end

    always_comb begin
        rd_data = CODE_PIN;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (idx_ok && (int'(core_idx) == i)) rd_data = mode_q[i];
        end
    end
endmodule

// File: rtl/pwr_core_fsm.sv
module pwr_core_fsm
    import pwr_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_code,
    input  logic [1:0] pin_code,
    output logic       nap_en,
    output logic       sleep_en
);
    pstate_t state_q;
    pstate_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    // Transitions: REG_GO, PIN_GO, HOLD
    always_comb begin
        state_d = state_q;
        if (mode_code != CODE_PIN) begin
            unique case (mode_code)
                CODE_NORMAL: state_d = ST_NORMAL;
                CODE_NAP:    state_d = ST_NAP;
                CODE_SLEEP:  state_d = ST_SLEEP;
                default:     state_d = state_q;
            endcase
        end else begin
            unique case (pin_code)
                LVL_LOW:  state_d = ST_SLEEP;
                LVL_MID:  state_d = ST_NORMAL;
                LVL_HIGH: state_d = ST_NAP;
                default:  state_d = state_q;
            endcase
        end
    end

    // Outputs
    always_comb begin
        nap_en   = 1'b0;
        sleep_en = 1'b0;
        unique case (state_q)
            ST_NAP:   nap_en   = 1'b1;
            ST_SLEEP: sleep_en = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int NUM_CORES = 2,
    localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic [1:0]           pin_lvl,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     core_idx,
    input  logic [2:0]           wr_data,
    output logic [2:0]           rd_data,
    output logic [NUM_CORES-1:0] nap_en,
    output logic [NUM_CORES-1:0] sleep_en
);
    logic [1:0]             pin_sync_q;
    logic [NUM_CORES*3-1:0] mode_flat;

    pwr_pin_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .lvl_in   (pin_lvl),
        .lvl_sync (pin_sync_q)
    );

    pwr_mode_regs #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .core_idx  (core_idx),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .mode_flat (mode_flat)
    );

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        pwr_core_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_code (mode_flat[g*3 +: 3]),
            .pin_code  (pin_sync_q),
            .nap_en    (nap_en[g]),
            .sleep_en  (sleep_en[g])
        );
    end
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
    parameter int NUM_CORES = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   soft_rst,
    input logic                   wr_en,
    input logic [2:0]             wr_data,
    input logic [1:0]             pin_sync_q,
    input logic [NUM_CORES*3-1:0] mode_flat,
    input logic [NUM_CORES-1:0]   nap_en,
    input logic [NUM_CORES-1:0]   sleep_en
);
    logic wr_bad;
    assign wr_bad = wr_en && !((wr_data == 3'b000) || (wr_data == 3'b001) ||
                               (wr_data == 3'b010) || (wr_data == 3'b100));

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (nap_en & sleep_en) == '0);

    p_bad_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bad |=> $stable(mode_flat));

    p_soft_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !wr_en) |=> $stable(mode_flat));

    p_soft_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (pin_sync_q == 2'b01));

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core_chk
        p_pin_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_flat[g*3 +: 3] == 3'b000 && pin_sync_q == 2'b00) |=> sleep_en[g]);
        p_pin_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_flat[g*3 +: 3] == 3'b000 && pin_sync_q == 2'b11)
            |=> ($stable(nap_en[g]) && $stable(sleep_en[g])));
        p_reg_nap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_flat[g*3 +: 3] == 3'b010) |=> (nap_en[g] && !sleep_en[g]));
        p_reg_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_flat[g*3 +: 3] == 3'b100) |=> (sleep_en[g] && !nap_en[g]));
    end
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .pin_sync_q (pin_sync_q),
    .mode_flat  (mode_flat),
    .nap_en     (nap_en),
    .sleep_en   (sleep_en)
);

// File: tb/pwr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_bench;
    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         soft_rst = 1'b0;
    logic [1:0]   pin_lvl = 2'b01;
    logic         wr_en = 1'b0;
    logic [0:0]   core_idx = '0;
    logic [2:0]   wr_data = '0;
    logic [2:0]   rd_data;
    logic [N-1:0] nap_en;
    logic [N-1:0] sleep_en;

    int    vectors = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string phase = "R1";

    // Reference model: state 0 normal, 1 nap, 2 sleep
    int m_reg [N];
    int m_st  [N];
    int m_s1, m_s2;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl #(.NUM_CORES(N)) u_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .pin_lvl(pin_lvl),
        .wr_en(wr_en), .core_idx(core_idx), .wr_data(wr_data),
        .rd_data(rd_data), .nap_en(nap_en), .sleep_en(sleep_en)
    );

    function automatic bit legal(int c);
        return (c == 0) || (c == 1) || (c == 2) || (c == 4);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_reg[i] = 0; m_st[i] = 0; end
            m_s1 = 1; m_s2 = 1;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (m_reg[i] == 1)      m_st[i] = 0;
                else if (m_reg[i] == 2) m_st[i] = 1;
                else if (m_reg[i] == 4) m_st[i] = 2;
                else if (m_s2 == 0)     m_st[i] = 2;
                else if (m_s2 == 1)     m_st[i] = 0;
                else if (m_s2 == 2)     m_st[i] = 1;
            end
            if (wr_en && legal(int'(wr_data)) && int'(core_idx) < N)
                m_reg[core_idx] = int'(wr_data);
            if (soft_rst) begin m_s2 = 1; m_s1 = 1; end
            else begin m_s2 = m_s1; m_s1 = int'(pin_lvl); end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            for (int i = 0; i < N; i++) begin
                vectors++;
                if (nap_en[i] !== (m_st[i] == 1)) begin
                    fails++;
                    $display("FAIL %s core%0d nap_en act=%b exp=%b", phase, i, nap_en[i], m_st[i] == 1);
                end
                vectors++;
                if (sleep_en[i] !== (m_st[i] == 2)) begin
                    fails++;
                    $display("FAIL %s core%0d sleep_en act=%b exp=%b", phase, i, sleep_en[i], m_st[i] == 2);
                end
            end
            vectors++;
            if (rd_data !== 3'(m_reg[core_idx])) begin
                fails++;
                $display("FAIL %s rd_data act=%b exp=%b", phase, rd_data, 3'(m_reg[core_idx]));
            end
            vectors++;  // R9 exclusivity
            if ((nap_en & sleep_en) !== '0) begin
                fails++;
                $display("FAIL R9 nap&sleep act=%b exp=%b", nap_en & sleep_en, {N{1'b0}});
            end
        end
    end

    task automatic cyc(int n);
        for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
    endtask

    task automatic wr(int idx, logic [2:0] d);
        core_idx = 1'(idx); wr_data = d; wr_en = 1'b1;
        cyc(1);
        wr_en = 1'b0;
    endtask

    initial begin
        phase = "R1"; cyc(3); rst_n = 1'b1; cyc(2);
        phase = "R2"; pin_lvl = 2'b00; cyc(5);
        pin_lvl = 2'b10; cyc(5);
        pin_lvl = 2'b01; cyc(5);
        pin_lvl = 2'b00; cyc(5);
        phase = "R3"; pin_lvl = 2'b11; cyc(6);
        pin_lvl = 2'b10; cyc(5);
        pin_lvl = 2'b11; cyc(4);
        phase = "R4"; wr(0, 3'b100); cyc(2);
        wr(1, 3'b001); cyc(2);
        wr(0, 3'b010); cyc(2);
        phase = "R7"; core_idx = 1'b1; cyc(3);
        core_idx = 1'b0; cyc(2);
        pin_lvl = 2'b00; cyc(5);
        phase = "R6"; wr(0, 3'b011); wr(0, 3'b111); wr(1, 3'b101); wr(1, 3'b110); cyc(3);
        phase = "R5"; wr(0, 3'b000); cyc(3);
        pin_lvl = 2'b10; cyc(5);
        phase = "R8"; wr(1, 3'b100); pin_lvl = 2'b00; cyc(5);
        soft_rst = 1'b1; cyc(1); soft_rst = 1'b0; core_idx = 1'b0; cyc(6);
        core_idx = 1'b1; cyc(2);
        phase = "R1"; rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(3);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule